// File: doc/BRIEF.md
# Paired-Width Floating-Point Register File

This block holds the raw bit contents of a floating-point architectural register file built from 32-bit words. It has one write port and one read port. Each port takes a register index and a width code. A single-width access touches one 32-bit word. A double-width access at index n covers two words: the low half sits at word n and the high half at word n+1. Above the data registers sit five 32-bit control words. Their order is identification, condition codes, exceptions, enables, and control/status. These control words accept only single-width access.

Writes commit on the rising clock edge. Reads are combinational from the current storage. Each port flags an illegal request with an error output in the same cycle. An illegal request changes no storage and reads back as zero. A synchronous clear input zeroes every word, and it takes priority over a write in the same cycle. Arithmetic and the meaning of the control bits are outside this block.

Top module: `fpRegFile`

## Requirements
- R1: Reset and a cycle with `clear` high both set every word to zero, the control words at indices 32 to 36 included.
- R2: With width code 2'b01 (single), a legal read returns the 32-bit word at `rdIdx` in `rdData[31:0]`, with `rdData[63:32]` zero.
- R3: A legal single-width write stores `wrData[31:0]` into word n only. `wrData[63:32]` is ignored and word n+1 keeps its value.
- R4: With width code 2'b10 (double), a legal write stores `wrData[63:32]` into word n+1 and `wrData[31:0]` into word n.
- R5: A legal double-width read returns {word[n+1], word[n]} on `rdData`.
- R6: Indices 32 to 36 are single-width control words. They are written and read like data words.
- R7: A request is illegal when any of these holds: the width code is 2'b00 or 2'b11, the index is 37 or above, or it is double-width at index 31 or above. An illegal request raises that port's error output in the same cycle (for writes, only while `wrEn` is high). An illegal write changes no word. An illegal read drives `rdData` to zero.
- R8: A read in the same cycle as a write to the same word returns the old contents. The new value is visible from the next cycle.
- R9: When `clear` and a legal write fall in the same cycle, all words end up zero.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Zero all storage at the next edge |
| wrEn | input | 1 | Write request |
| wrIdx | input | 6 | Write word index |
| wrWidth | input | 2 | Write width code: 01 single, 10 double |
| wrData | input | 64 | Write data; only bits 31:0 are used for single width |
| rdIdx | input | 6 | Read word index |
| rdWidth | input | 2 | Read width code |
| rdData | output | 64 | Read data |
| wrErr | output | 1 | Write request is illegal |
| rdErr | output | 1 | Read request is illegal |

## Verification
Two collisions can land in the same cycle: a write with a read of the same word, and a write with `clear`. The bench provokes the first by presenting a write and a read of index n together. It judges the result by checking that `rdData` shows the old value before the edge and the new value after it. It provokes the second by raising `clear` while a legal write is pending. It judges that case by reading the target word and its neighbours back as zero on the following cycles.

// File: rtl/fpRfPkg.sv
package fpRfPkg;
  localparam int RF_IDX_W = 6;

  localparam logic [1:0] WID_SINGLE = 2'b01;
  localparam logic [1:0] WID_DOUBLE = 2'b10;

  typedef struct packed {
    logic                clearAll;
    logic                wrLo;
    logic                wrHi;
    logic [RF_IDX_W-1:0] wrLoIdx;
    logic [RF_IDX_W-1:0] wrHiIdx;
    logic                rdOk;
    logic                rdDouble;
    logic [RF_IDX_W-1:0] rdLoIdx;
    logic [RF_IDX_W-1:0] rdHiIdx;
  } rfStrobes_t;
endpackage

// File: rtl/fpRfCtrl.sv
module fpRfCtrl
  import fpRfPkg::*;
#(
  parameter int DATA_REGS = 32,
  parameter int CTRL_REGS = 5
) (
  input  logic                clear,
  input  logic                wrEn,
  input  logic [RF_IDX_W-1:0] wrIdx,
  input  logic [1:0]          wrWidth,
  input  logic [RF_IDX_W-1:0] rdIdx,
  input  logic [1:0]          rdWidth,
  output rfStrobes_t          strobes,
  output logic                wrErr,
  output logic                rdErr
);
  localparam int NUM_WORDS = DATA_REGS + CTRL_REGS;
  localparam logic [RF_IDX_W-1:0] LAST_WORD = RF_IDX_W'(NUM_WORDS - 1);
  localparam logic [RF_IDX_W-1:0] LAST_PAIR = RF_IDX_W'(DATA_REGS - 2);

  logic wrSingleOk, wrDoubleOk, rdSingleOk, rdDoubleOk;

  always_comb begin
    wrSingleOk = (wrWidth == WID_SINGLE) && (wrIdx <= LAST_WORD);
    wrDoubleOk = (wrWidth == WID_DOUBLE) && (wrIdx <= LAST_PAIR);
    rdSingleOk = (rdWidth == WID_SINGLE) && (rdIdx <= LAST_WORD);
    rdDoubleOk = (rdWidth == WID_DOUBLE) && (rdIdx <= LAST_PAIR);

    wrErr = wrEn && !(wrSingleOk || wrDoubleOk);
    rdErr = !(rdSingleOk || rdDoubleOk);

    strobes.clearAll = clear;
    strobes.wrLo     = wrEn && (wrSingleOk || wrDoubleOk);
    strobes.wrHi     = wrEn && wrDoubleOk;
    strobes.wrLoIdx  = (wrSingleOk || wrDoubleOk) ? wrIdx : '0;
    strobes.wrHiIdx  = wrDoubleOk ? wrIdx + RF_IDX_W'(1) : '0;
    strobes.rdOk     = rdSingleOk || rdDoubleOk;
    strobes.rdDouble = rdDoubleOk;
    strobes.rdLoIdx  = (rdSingleOk || rdDoubleOk) ? rdIdx : '0;
    strobes.rdHiIdx  = rdDoubleOk ? rdIdx + RF_IDX_W'(1) : '0;
  end
endmodule

// File: rtl/fpRfData.sv
module fpRfData
  import fpRfPkg::*;
#(
  parameter int DATA_REGS = 32,
  parameter int CTRL_REGS = 5,
  parameter int WORD_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rfStrobes_t        strobes,
  input  logic [2*WORD_W-1:0] wrData,
  output logic [2*WORD_W-1:0] rdData
);
  localparam int NUM_WORDS = DATA_REGS + CTRL_REGS;

  logic [WORD_W-1:0] words [NUM_WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n || strobes.clearAll) begin
      for (int i = 0; i < NUM_WORDS; i++) words[i] <= '0;
    end else begin
      if (strobes.wrLo) words[strobes.wrLoIdx] <= wrData[WORD_W-1:0];
      if (strobes.wrHi) words[strobes.wrHiIdx] <= wrData[2*WORD_W-1:WORD_W];
    end
  end

  always_comb begin
    if (!strobes.rdOk)
      rdData = '0;
    else if (strobes.rdDouble)
      rdData = {words[strobes.rdHiIdx], words[strobes.rdLoIdx]};
    else
      rdData = {{WORD_W{1'b0}}, words[strobes.rdLoIdx]};
  end
endmodule

// File: rtl/fpRegFile.sv
module fpRegFile
  import fpRfPkg::*;
#(
  parameter int DATA_REGS = 32,
  parameter int CTRL_REGS = 5,
  parameter int WORD_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                wrEn,
  input  logic [5:0]          wrIdx,
  input  logic [1:0]          wrWidth,
  input  logic [63:0]         wrData,
  input  logic [5:0]          rdIdx,
  input  logic [1:0]          rdWidth,
  output logic [63:0]         rdData,
  output logic                wrErr,
  output logic                rdErr
);
  rfStrobes_t strobes;

  fpRfCtrl #(.DATA_REGS(DATA_REGS), .CTRL_REGS(CTRL_REGS)) uCtrl (
    .clear(clear), .wrEn(wrEn), .wrIdx(wrIdx), .wrWidth(wrWidth),
    .rdIdx(rdIdx), .rdWidth(rdWidth), .strobes(strobes),
    .wrErr(wrErr), .rdErr(rdErr)
  );

  fpRfData #(.DATA_REGS(DATA_REGS), .CTRL_REGS(CTRL_REGS), .WORD_W(WORD_W)) uData (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .wrData(wrData), .rdData(rdData)
  );
endmodule

// File: rtl/fpRfChecker.sv
module fpRfChecker #(
  parameter int DATA_REGS = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        clear,
  input logic        wrEn,
  input logic [5:0]  wrIdx,
  input logic [1:0]  wrWidth,
  input logic [63:0] wrData,
  input logic [5:0]  rdIdx,
  input logic [1:0]  rdWidth,
  input logic [63:0] rdData,
  input logic        wrErr,
  input logic        rdErr
);
  p_rd_err_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rdErr |-> rdData == 64'd0);

  p_double_ctrl_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rdWidth == 2'b10 && rdIdx >= 6'(DATA_REGS - 1)) |-> rdErr);

  p_single_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rdWidth == 2'b01 && !rdErr) |-> rdData[63:32] == 32'd0);

  p_clear_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> rdData == 64'd0);

  p_bad_write_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrErr && !clear) |=>
      (!($stable(rdIdx) && $stable(rdWidth)) || $stable(rdData)));

  p_double_roundtrip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((wrEn && !wrErr && !clear && wrWidth == 2'b10) ##1
     (rdIdx == $past(wrIdx) && rdWidth == 2'b10)) |-> rdData == $past(wrData));
endmodule

bind fpRegFile fpRfChecker #(.DATA_REGS(DATA_REGS)) uChk (.*);

// File: tb/sim_fpRegFile.sv
module sim_fpRegFile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        wrEn = 1'b0;
  logic [5:0]  wrIdx = '0;
  logic [1:0]  wrWidth = 2'b01;
  logic [63:0] wrData = '0;
  logic [5:0]  rdIdx = '0;
  logic [1:0]  rdWidth = 2'b01;
  logic [63:0] rdData;
  logic        wrErr, rdErr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fpRegFile u0 (.*);

  task automatic checkEq(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic readChk(string tag, logic [5:0] idx, logic [1:0] w,
                         logic [63:0] exp, logic expErr);
    @(negedge clk);
    rdIdx = idx; rdWidth = w;
    #1;
    checkEq(tag, rdData, exp);
    checkEq({tag, " err"}, {63'd0, rdErr}, {63'd0, expErr});
  endtask

  task automatic doWrite(string tag, logic [5:0] idx, logic [1:0] w,
                         logic [63:0] d, logic expErr);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrWidth = w; wrData = d;
    #1;
    checkEq({tag, " wrErr"}, {63'd0, wrErr}, {63'd0, expErr});
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic testReset();
    for (int i = 0; i < 37; i++) readChk("R1 reset zero", 6'(i), 2'b01, 64'd0, 1'b0);
  endtask

  task automatic testSingle();
    doWrite("R3 single", 6'd5, 2'b01, 64'hAAAA5555_DEADBEEF, 1'b0);
    readChk("R2 single read", 6'd5, 2'b01, 64'h00000000_DEADBEEF, 1'b0);
    readChk("R3 neighbour untouched", 6'd6, 2'b01, 64'd0, 1'b0);
  endtask

  task automatic testDouble();
    doWrite("R4 double", 6'd10, 2'b10, 64'h11223344_55667788, 1'b0);
    readChk("R4 low word", 6'd10, 2'b01, 64'h55667788, 1'b0);
    readChk("R4 high word", 6'd11, 2'b01, 64'h11223344, 1'b0);
    readChk("R5 double read", 6'd10, 2'b10, 64'h11223344_55667788, 1'b0);
    doWrite("R4 top pair", 6'd30, 2'b10, 64'hCAFEF00D_0BADC0DE, 1'b0);
    readChk("R5 top pair read", 6'd30, 2'b10, 64'hCAFEF00D_0BADC0DE, 1'b0);
    readChk("R5 odd pair read", 6'd11, 2'b10, 64'h00000000_11223344, 1'b0);
  endtask

  task automatic testControl();
    for (int i = 32; i < 37; i++)
      doWrite("R6 ctrl write", 6'(i), 2'b01, {32'hFFFFFFFF, 32'hC0DE0000 + 32'(i)}, 1'b0);
    for (int i = 32; i < 37; i++)
      readChk("R6 ctrl read", 6'(i), 2'b01, {32'd0, 32'hC0DE0000 + 32'(i)}, 1'b0);
  endtask

  task automatic testIllegal();
    doWrite("R7 double at 31", 6'd31, 2'b10, 64'h12345678_9ABCDEF0, 1'b1);
    readChk("R7 word31 kept", 6'd31, 2'b01, 64'hCAFEF00D, 1'b0);
    readChk("R7 word32 kept", 6'd32, 2'b01, 64'hC0DE0020, 1'b0);
    doWrite("R7 double ctrl", 6'd33, 2'b10, 64'h1, 1'b1);
    readChk("R7 ctrl kept", 6'd33, 2'b01, 64'hC0DE0021, 1'b0);
    doWrite("R7 width 00", 6'd5, 2'b00, 64'h1, 1'b1);
    doWrite("R7 width 11", 6'd5, 2'b11, 64'h1, 1'b1);
    readChk("R7 word5 kept", 6'd5, 2'b01, 64'hDEADBEEF, 1'b0);
    doWrite("R7 index 40", 6'd40, 2'b01, 64'h1, 1'b1);
    readChk("R7 read double ctrl", 6'd32, 2'b10, 64'd0, 1'b1);
    readChk("R7 read double 31", 6'd31, 2'b10, 64'd0, 1'b1);
    readChk("R7 read width 11", 6'd5, 2'b11, 64'd0, 1'b1);
    readChk("R7 read index 37", 6'd37, 2'b01, 64'd0, 1'b1);
  endtask

  task automatic testCollide();
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 6'd5; wrWidth = 2'b01; wrData = 64'h0000_0000_13579BDF;
    rdIdx = 6'd5; rdWidth = 2'b01;
    #1;
    checkEq("R8 old value same cycle", rdData, 64'hDEADBEEF);
    @(negedge clk);
    wrEn = 1'b0;
    #1;
    checkEq("R8 new value next cycle", rdData, 64'h13579BDF);
  endtask

  task automatic testClear();
    @(negedge clk);
    clear = 1'b1; wrEn = 1'b1; wrIdx = 6'd7; wrWidth = 2'b10; wrData = 64'hFFFF0000_FFFF0000;
    @(negedge clk);
    clear = 1'b0; wrEn = 1'b0;
    readChk("R9 clear beats write lo", 6'd7, 2'b01, 64'd0, 1'b0);
    readChk("R9 clear beats write hi", 6'd8, 2'b01, 64'd0, 1'b0);
    for (int i = 0; i < 37; i++) readChk("R1 clear zero", 6'(i), 2'b01, 64'd0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testSingle();
    testDouble();
    testControl();
    testIllegal();
    testCollide();
    testClear();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule